// File: doc/BRIEF.md
# Receive Stream Admission Controller

This block sits at the entry of a stream-to-memory DMA engine and decides, one packet at a time, what happens to each incoming packet. A packet whose first beat finds a receive descriptor in the local prefetch buffer is passed through to the downstream write path unchanged. A packet that finds no descriptor is held at the stream boundary while a programmable wait timer runs, and is discarded if the timer expires and the configured drop test says no descriptor can be expected. Packets are also discarded while the flush control is set.

Software steers the engine with one-shot start, stop and abort requests and reads back a 2-bit engine state. Stop, disable and flush act only between packets, so a packet that has begun is never cut short by them. Abort acts at once, even inside a packet. A single-cycle hint pulse reports that a packet has started waiting for a descriptor, and a counter records every discarded packet.

Top module: `rx_admit_ctrl`

## Requirements
- R1: After a synchronous reset the engine state is 00, `s_ready`, `m_valid` and `hint` are 0, and `drop_count` is 0.
- R2: The engine state encodes 00 idle, 01 active, 10 aborted; 11 never appears. A request with only bit 0 of `cmd_req` set, written while idle or aborted, makes the state 01 from the next cycle.
- R3: While active and between packets, a packet whose first beat sees `desc_local`=1 is forwarded: `m_valid` follows `s_valid`, `s_ready` follows `m_ready`, and `m_data`/`m_last` equal `s_data`/`s_last` until the beat with `s_last`=1 is accepted. Nothing is forwarded outside the active state.
- R4: `cfg_disable` is honoured only between packets: a packet already started completes, and no new first beat is accepted while the bit is set.
- R5: With `cfg_flush`=1 and the engine not aborted, at each packet boundary `s_ready` is 1 and `m_valid` is 0, so whole packets are consumed and discarded.
- R6: A first beat arriving while active and admitted but with `desc_local`=0 is held with `s_ready`=0; when `cfg_hint_en`=1, `hint` is high for exactly one cycle, the cycle after the first held cycle.
- R7: The wait timer restarts at zero for each held packet; if a held packet is to be dropped, `s_ready` rises `cfg_wait_limit`+2 cycles after the first held cycle and the packet's beats are then consumed without being forwarded.
- R8: A held packet is dropped only when `cfg_drop_en`=1 and the drop test holds: with `cfg_local_only`=1 the test is "no local descriptor", with `cfg_local_only`=0 it is "`desc_any`=0". With `cfg_drop_en`=0 a held packet waits indefinitely; a local descriptor arriving during the wait releases it for forwarding.
- R9: `drop_count` increases by exactly one when the last beat of each discarded packet (flush or timer drop) is accepted, and by no other amount.
- R10: A request with bit 2 of `cmd_req` set makes the state 10 from the next cycle, even mid-packet; while aborted `s_ready` and `m_valid` are 0 and the state stays 10 until a start request.
- R11: A request with bit 1 of `cmd_req` set while active blocks new packets; the state goes to 00 one cycle after the current packet's last beat is accepted. When several request bits are set together, abort wins over stop, and stop over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Strobe qualifying `cmd_req` for one cycle |
| cmd_req | input | 3 | Request bits: 0 start, 1 stop, 2 abort |
| cfg_disable | input | 1 | Refuse new packets at the next boundary |
| cfg_flush | input | 1 | Consume and discard packets at boundaries |
| cfg_drop_en | input | 1 | Allow dropping a packet that lacks a descriptor |
| cfg_hint_en | input | 1 | Enable the no-descriptor hint pulse |
| cfg_local_only | input | 1 | Drop test: 1 local buffer only, 0 anywhere |
| cfg_wait_limit | input | TMR_W | Cycles a held packet may wait before a drop |
| desc_local | input | 1 | A descriptor is present in the prefetch buffer |
| desc_any | input | 1 | A descriptor exists somewhere (buffer or host) |
| s_valid | input | 1 | Incoming beat valid |
| s_ready | output | 1 | Incoming beat accepted |
| s_data | input | DATA_W | Incoming beat payload |
| s_last | input | 1 | Incoming beat ends the packet |
| m_valid | output | 1 | Forwarded beat valid |
| m_ready | input | 1 | Downstream accepts forwarded beat |
| m_data | output | DATA_W | Forwarded beat payload |
| m_last | output | 1 | Forwarded beat ends the packet |
| eng_state | output | 2 | Engine state 00 idle, 01 active, 10 aborted |
| hint | output | 1 | One-cycle pulse: a packet began waiting for a descriptor |
| drop_count | output | CNT_W | Number of discarded packets |

## Verification
The forwarding path is tried with single-beat and multi-beat packets, with and without a stalling downstream, which separates a correct handshake pass-through from one that drops or repeats beats. Held packets are tried with a descriptor that arrives late, with drops disabled, and with both drop tests at several timer limits including zero, so that the hold-versus-drop choice and the exact release cycle of the timer are told apart. Disable, stop and abort are each raised inside a packet, which distinguishes boundary-only controls from the immediate one, and a combined request shows the priority order. Flush runs over packets of different lengths to show that every packet is consumed whole and counted once.

// File: rtl/rxadm_pkg.sv
`timescale 1ns/1ps
package rxadm_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE   = 2'b00,
    ENG_ACTIVE = 2'b01,
    ENG_ABORT  = 2'b10
  } eng_state_e;

  typedef enum logic [1:0] {
    PK_BOUND = 2'b00,
    PK_PASS  = 2'b01,
    PK_DROP  = 2'b10
  } pkt_state_e;

  localparam int REQ_W     = 3;
  localparam int REQ_START = 0;
  localparam int REQ_STOP  = 1;
  localparam int REQ_ABORT = 2;

endpackage

// File: rtl/rxadm_engine.sv
`timescale 1ns/1ps
module rxadm_engine
  import rxadm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [REQ_W-1:0] cmd_req,
  input  logic             pkt_bound,
  output eng_state_e       eng,
  output logic             stop_pend,
  output logic             abort_req
);

  logic stop_req, start_req;

  assign abort_req = cmd_wr && cmd_req[REQ_ABORT];
  assign stop_req  = cmd_wr && cmd_req[REQ_STOP];
  assign start_req = cmd_wr && cmd_req[REQ_START];

  // Priority: abort, then a pending stop draining, then stop, then start.
  always_ff @(posedge clk) begin
    if (rst) begin
      eng       <= ENG_IDLE;
      stop_pend <= 1'b0;
    end else if (abort_req) begin
      eng       <= ENG_ABORT;
      stop_pend <= 1'b0;
    end else if (stop_pend && pkt_bound) begin
      eng       <= ENG_IDLE;
      stop_pend <= 1'b0;
    end else if (stop_req) begin
      if (eng == ENG_ACTIVE) stop_pend <= 1'b1;
    end else if (start_req && eng != ENG_ACTIVE) begin
      eng <= ENG_ACTIVE;
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    eng != 2'b11) else $error("illegal engine state"); // R2

  AST_ABORT_NEXT: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> eng == ENG_ABORT) else $error("abort not taken"); // R10

  AST_START_RESUMES: assert property (@(posedge clk) disable iff (rst)
    (start_req && !stop_req && !abort_req && eng != ENG_ACTIVE) |=> eng == ENG_ACTIVE)
    else $error("start not taken"); // R2

  AST_STOP_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (stop_pend && pkt_bound && !abort_req) |=> eng == ENG_IDLE)
    else $error("stop did not reach idle"); // R11

  AST_STOP_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    stop_pend |-> eng == ENG_ACTIVE) else $error("stop pending outside active"); // R11

endmodule

// File: rtl/rxadm_wait_timer.sv
`timescale 1ns/1ps
module rxadm_wait_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want,
  input  logic             clear,
  input  logic [TMR_W-1:0] limit,
  output logic             armed,
  output logic             expired
);

  localparam logic [TMR_W-1:0] CNT_MAX = {TMR_W{1'b1}};

  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !want || clear) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (!armed) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = armed && (cnt >= limit);

  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (rst)
    (want && !clear && !armed) |=> (armed && cnt == '0))
    else $error("timer did not restart"); // R7

  AST_TMR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (want && !clear && armed && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1)
    else $error("timer did not advance"); // R7

endmodule

// File: rtl/rxadm_pkt_gate.sv
`timescale 1ns/1ps
module rxadm_pkt_gate
  import rxadm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter bit CNT_SAT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  eng_state_e        eng,
  input  logic              stop_pend,
  input  logic              abort_req,
  input  logic              cfg_disable,
  input  logic              cfg_flush,
  input  logic              cfg_drop_en,
  input  logic              cfg_hint_en,
  input  logic              cfg_local_only,
  input  logic              desc_local,
  input  logic              desc_any,
  input  logic              tmr_armed,
  input  logic              tmr_expired,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic              pkt_bound,
  output logic              want_wait,
  output logic              drop_go,
  output logic              hint,
  output logic [CNT_W-1:0]  drop_count
);

  pkt_state_e pst;
  logic admit, flushing, pass_path, no_desc, hs, drop_inc;

  assign pkt_bound = (pst == PK_BOUND);
  assign admit     = (eng == ENG_ACTIVE) && !cfg_flush && !cfg_disable && !stop_pend;
  assign flushing  = pkt_bound && (eng != ENG_ABORT) && cfg_flush;
  assign pass_path = pkt_bound && admit && desc_local;
  assign want_wait = pkt_bound && admit && s_valid && !desc_local;
  assign no_desc   = cfg_local_only ? !desc_local : !desc_any;
  assign drop_go   = want_wait && tmr_expired && cfg_drop_en && no_desc;

  assign m_data = s_data;
  assign m_last = s_last;

  always_comb begin
    s_ready = 1'b0;
    m_valid = 1'b0;
    if (eng != ENG_ABORT) begin
      unique case (pst)
        PK_BOUND: begin
          if (flushing) begin
            s_ready = 1'b1;
          end else if (pass_path) begin
            m_valid = s_valid;
            s_ready = m_ready;
          end
        end
        PK_PASS: begin
          m_valid = s_valid;
          s_ready = m_ready;
        end
        PK_DROP: s_ready = 1'b1;
        default: s_ready = 1'b0;
      endcase
    end
  end

  assign hs       = s_valid && s_ready;
  assign drop_inc = hs && s_last && ((pst == PK_DROP) || flushing);

  always_ff @(posedge clk) begin
    if (rst) begin
      pst  <= PK_BOUND;
      hint <= 1'b0;
    end else begin
      hint <= want_wait && !tmr_armed && cfg_hint_en;
      if (abort_req) begin
        pst <= PK_BOUND;
      end else begin
        unique case (pst)
          PK_BOUND: begin
            if (flushing) begin
              if (hs && !s_last) pst <= PK_DROP;
            end else if (pass_path) begin
              if (hs && !s_last) pst <= PK_PASS;
            end else if (drop_go) begin
              pst <= PK_DROP;
            end
          end
          PK_PASS, PK_DROP: if (hs && s_last) pst <= PK_BOUND;
          default: pst <= PK_BOUND;
        endcase
      end
    end
  end

  generate
    if (CNT_SAT) begin : g_cnt_sat
      always_ff @(posedge clk) begin
        if (rst) drop_count <= '0;
        else if (drop_inc && drop_count != {CNT_W{1'b1}}) drop_count <= drop_count + 1'b1;
      end
    end else begin : g_cnt_wrap
      always_ff @(posedge clk) begin
        if (rst) drop_count <= '0;
        else if (drop_inc) drop_count <= drop_count + 1'b1;
      end
    end
  endgenerate

  AST_ABORT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (eng == ENG_ABORT) |-> (!s_ready && !m_valid)) else $error("traffic while aborted"); // R10

  AST_FLUSH_DISCARD: assert property (@(posedge clk) disable iff (rst)
    flushing |-> (s_ready && !m_valid)) else $error("flush forwarded data"); // R5

  AST_FWD_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (eng == ENG_ACTIVE)) else $error("forward outside active"); // R3

  AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (rst)
    want_wait |-> !s_ready) else $error("held head accepted"); // R6

  AST_HINT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    hint |=> !hint) else $error("hint longer than one cycle"); // R6

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_count == $past(drop_count) ||
              drop_count == CNT_W'($past(drop_count) + 1'b1)))
    else $error("drop counter jumped"); // R9

endmodule

// File: rtl/rx_admit_ctrl.sv
`timescale 1ns/1ps
module rx_admit_ctrl
  import rxadm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TMR_W   = 24,
  parameter int CNT_W   = 16,
  parameter bit CNT_SAT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [2:0]        cmd_req,
  input  logic              cfg_disable,
  input  logic              cfg_flush,
  input  logic              cfg_drop_en,
  input  logic              cfg_hint_en,
  input  logic              cfg_local_only,
  input  logic [TMR_W-1:0]  cfg_wait_limit,
  input  logic              desc_local,
  input  logic              desc_any,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic [1:0]        eng_state,
  output logic              hint,
  output logic [CNT_W-1:0]  drop_count
);

  eng_state_e eng;
  logic stop_pend, abort_req, pkt_bound;
  logic want_wait, drop_go, tmr_armed, tmr_expired;

  rxadm_engine u_engine (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_req   (cmd_req),
    .pkt_bound (pkt_bound),
    .eng       (eng),
    .stop_pend (stop_pend),
    .abort_req (abort_req)
  );

  rxadm_wait_timer #(.TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .want    (want_wait),
    .clear   (drop_go),
    .limit   (cfg_wait_limit),
    .armed   (tmr_armed),
    .expired (tmr_expired)
  );

  rxadm_pkt_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CNT_SAT(CNT_SAT)) u_gate (
    .clk            (clk),
    .rst            (rst),
    .eng            (eng),
    .stop_pend      (stop_pend),
    .abort_req      (abort_req),
    .cfg_disable    (cfg_disable),
    .cfg_flush      (cfg_flush),
    .cfg_drop_en    (cfg_drop_en),
    .cfg_hint_en    (cfg_hint_en),
    .cfg_local_only (cfg_local_only),
    .desc_local     (desc_local),
    .desc_any       (desc_any),
    .tmr_armed      (tmr_armed),
    .tmr_expired    (tmr_expired),
    .s_valid        (s_valid),
    .s_ready        (s_ready),
    .s_data         (s_data),
    .s_last         (s_last),
    .m_valid        (m_valid),
    .m_ready        (m_ready),
    .m_data         (m_data),
    .m_last         (m_last),
    .pkt_bound      (pkt_bound),
    .want_wait      (want_wait),
    .drop_go        (drop_go),
    .hint           (hint),
    .drop_count     (drop_count)
  );

  assign eng_state = eng;

endmodule

// File: tb/sim_rx_admit_ctrl.sv
`timescale 1ns/1ps
module sim_rx_admit_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [2:0]  cmd_req = '0;
  logic        cfg_disable = 1'b0, cfg_flush = 1'b0, cfg_drop_en = 1'b0;
  logic        cfg_hint_en = 1'b0, cfg_local_only = 1'b0;
  logic [23:0] cfg_wait_limit = '0;
  logic        desc_local = 1'b0, desc_any = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b1;
  logic [31:0] s_data = '0;
  wire         s_ready, m_valid, m_last, hint;
  wire  [31:0] m_data;
  wire  [1:0]  eng_state;
  wire  [15:0] drop_count;

  always #2.5 clk = ~clk;

  rx_admit_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_req(cmd_req),
    .cfg_disable(cfg_disable), .cfg_flush(cfg_flush), .cfg_drop_en(cfg_drop_en),
    .cfg_hint_en(cfg_hint_en), .cfg_local_only(cfg_local_only),
    .cfg_wait_limit(cfg_wait_limit), .desc_local(desc_local), .desc_any(desc_any),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .eng_state(eng_state), .hint(hint), .drop_count(drop_count)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, n_fwd = 0, n_hint = 0;
  bit bp_on = 1'b0, obs_hs = 1'b0, finished = 1'b0;

  // behavioural reference state
  int me = 0, mp = 0, mcnt = 0, mdrops = 0;
  bit mstop = 0, mwait = 0, mhint = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // One clock: compare DUT with the reference, then advance the reference.
  task automatic tick();
    bit bound, adm, flsh, pass, ww, nodesc, dgo, e_rdy, e_mv, hs, ab, st, sa, dinc;
    if (bp_on) m_ready = (cyc % 3) != 0;
    cyc++;
    #1;
    bound = (mp == 0);
    adm   = (me == 1) && !cfg_flush && !cfg_disable && !mstop;
    flsh  = bound && (me != 2) && cfg_flush;
    pass  = bound && adm && desc_local;
    ww    = bound && adm && s_valid && !desc_local;
    nodesc = cfg_local_only ? !desc_local : !desc_any;
    dgo   = ww && mwait && (mcnt >= int'(cfg_wait_limit)) && cfg_drop_en && nodesc;
    e_rdy = 0; e_mv = 0;
    if (me != 2) begin
      if (mp == 1) begin e_mv = s_valid; e_rdy = m_ready; end
      else if (mp == 2) e_rdy = 1;
      else if (flsh) e_rdy = 1;
      else if (pass) begin e_mv = s_valid; e_rdy = m_ready; end
    end
    chk("R3", "s_ready", s_ready, e_rdy);
    chk("R3", "m_valid", m_valid, e_mv);
    if (e_mv) begin
      chk("R3", "m_data", m_data, s_data);
      chk("R3", "m_last", m_last, s_last);
    end
    chk("R2", "eng_state", eng_state, me);
    chk("R6", "hint", hint, mhint);
    chk("R9", "drop_count", drop_count, mdrops);
    obs_hs = s_valid && s_ready;
    if (m_valid && m_ready) n_fwd++;
    if (hint) n_hint++;
    hs = s_valid && e_rdy;
    ab = cmd_wr && cmd_req[2];
    st = cmd_wr && cmd_req[1];
    sa = cmd_wr && cmd_req[0];
    dinc = hs && s_last && ((mp == 2) || flsh);
    @(posedge clk);
    mhint = ww && !mwait && cfg_hint_en;
    if (!ww || dgo) begin mwait = 0; mcnt = 0; end
    else if (!mwait) begin mwait = 1; mcnt = 0; end
    else mcnt++;
    if (dinc) mdrops++;
    if (ab) mp = 0;
    else if (mp == 0) begin
      if (flsh) begin if (hs && !s_last) mp = 2; end
      else if (pass) begin if (hs && !s_last) mp = 1; end
      else if (dgo) mp = 2;
    end else if (hs && s_last) mp = 0;
    if (ab) begin me = 2; mstop = 0; end
    else if (mstop && bound) begin me = 0; mstop = 0; end
    else if (st) begin if (me == 1) mstop = 1; end
    else if (sa && me != 1) me = 1;
    @(negedge clk);
  endtask

  task automatic req(input logic [2:0] bits);
    cmd_wr = 1'b1; cmd_req = bits;
    tick();
    cmd_wr = 1'b0; cmd_req = '0;
  endtask

  task automatic beat(input logic [31:0] d, input bit l, input int maxw, output int waited);
    s_valid = 1'b1; s_data = d; s_last = l; waited = 0;
    forever begin
      tick();
      if (obs_hs) break;
      waited++;
      if (waited > maxw) break;
    end
  endtask

  task automatic send_pkt(input int len, input logic [31:0] base, input int maxw, output int first_wait);
    int w;
    for (int i = 0; i < len; i++) begin
      beat(base + i, i == len - 1, maxw, w);
      if (i == 0) first_wait = w;
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic hold_head(input int n, output int hs_seen);
    hs_seen = 0;
    s_valid = 1'b1; s_last = 1'b1; s_data = 32'hBEEF;
    for (int i = 0; i < n; i++) begin
      tick();
      if (obs_hs) hs_seen++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int w, hs_cnt, f0, h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "eng after reset", eng_state, 0);
    chk("R1", "drops after reset", drop_count, 0);
    chk("R1", "hint after reset", hint, 0);
    tick(); tick();

    req(3'b001);
    chk("R2", "eng after start", eng_state, 1);

    // R3 forwarding, single and multi-beat
    desc_local = 1'b1;
    send_pkt(1, 32'h100, 50, w);
    send_pkt(3, 32'h200, 50, w);
    chk("R3", "beats forwarded", n_fwd, 4);
    bp_on = 1'b1;
    send_pkt(4, 32'h300, 50, w);
    bp_on = 1'b0; m_ready = 1'b1;
    chk("R3", "beats forwarded with stalls", n_fwd, 8);

    // R6/R8 held then released by a late descriptor
    desc_local = 1'b0; desc_any = 1'b1; cfg_drop_en = 1'b1; cfg_hint_en = 1'b1;
    cfg_wait_limit = 24'd3;
    h0 = n_hint;
    hold_head(30, hs_cnt);
    chk("R6", "held head not accepted", hs_cnt, 0);
    chk("R6", "one hint per wait", n_hint - h0, 1);
    chk("R8", "no drop while descriptor exists", drop_count, 0);
    desc_local = 1'b1;
    beat(32'h400, 1'b1, 10, w);
    s_valid = 1'b0;
    chk("R8", "released packet forwarded", n_fwd, 9);

    // R7 timer drop, local mode
    desc_local = 1'b0; cfg_local_only = 1'b1; cfg_wait_limit = 24'd5;
    f0 = n_fwd;
    send_pkt(3, 32'h500, 100, w);
    chk("R7", "held cycles before drop, limit 5", w, 7);
    chk("R9", "drop counted", drop_count, 1);
    chk("R7", "dropped beats not forwarded", n_fwd, f0);
    cfg_wait_limit = 24'd0;
    send_pkt(1, 32'h600, 100, w);
    chk("R7", "held cycles before drop, limit 0", w, 2);
    chk("R9", "second drop counted", drop_count, 2);

    // R8 drops disabled: wait indefinitely
    cfg_drop_en = 1'b0;
    hold_head(40, hs_cnt);
    chk("R8", "no drop when disabled", hs_cnt, 0);
    chk("R8", "count unchanged", drop_count, 2);
    desc_local = 1'b1;
    beat(32'h700, 1'b1, 10, w);
    s_valid = 1'b0;
    chk("R8", "waiting packet forwarded", n_fwd, 10);

    // R8 global mode, no descriptor anywhere
    desc_local = 1'b0; desc_any = 1'b0; cfg_local_only = 1'b0;
    cfg_drop_en = 1'b1; cfg_wait_limit = 24'd2;
    send_pkt(2, 32'h800, 100, w);
    chk("R8", "global drop timing", w, 4);
    chk("R9", "global drop counted", drop_count, 3);

    // R4 disable mid-packet
    desc_local = 1'b1; cfg_drop_en = 1'b0;
    beat(32'h900, 1'b0, 10, w);
    cfg_disable = 1'b1;
    hs_cnt = 0;
    for (int i = 1; i < 4; i++) begin
      beat(32'h900 + i, i == 3, 10, w);
      hs_cnt += w;
    end
    s_valid = 1'b0;
    chk("R4", "packet in progress completes", hs_cnt, 0);
    hold_head(20, hs_cnt);
    chk("R4", "new head refused", hs_cnt, 0);
    cfg_disable = 1'b0;
    beat(32'hA00, 1'b1, 10, w);
    s_valid = 1'b0;
    chk("R4", "accepted after clear", n_fwd, 15);

    // R5 flush discards whole packets
    cfg_flush = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      send_pkt(k, 32'hB00, 10, w);
      chk("R5", "flush consumes at once", w, 0);
    end
    chk("R9", "flushed packets counted", drop_count, 6);
    chk("R5", "nothing forwarded in flush", n_fwd, 15);
    cfg_flush = 1'b0;

    // R10 abort mid-packet
    beat(32'hC00, 1'b0, 10, w);
    beat(32'hC01, 1'b0, 10, w);
    s_data = 32'hC02;
    req(3'b100);
    chk("R10", "abort state", eng_state, 2);
    chk("R10", "ready low in abort", s_ready, 0);
    hold_head(10, hs_cnt);
    chk("R10", "no accept while aborted", hs_cnt, 0);
    chk("R10", "abort persists", eng_state, 2);
    s_valid = 1'b0;
    req(3'b001);
    chk("R2", "start from abort", eng_state, 1);

    // R11 stop drains the current packet
    beat(32'hD00, 1'b0, 10, w);
    s_data = 32'hD01;
    req(3'b010);
    chk("R11", "still active after stop", eng_state, 1);
    beat(32'hD02, 1'b1, 10, w);
    s_valid = 1'b0;
    tick();
    chk("R11", "idle after last beat", eng_state, 0);
    hold_head(10, hs_cnt);
    chk("R11", "no accept when idle", hs_cnt, 0);
    s_valid = 1'b0;

    // R11 priority: abort beats start
    req(3'b101);
    chk("R11", "abort wins over start", eng_state, 2);
    req(3'b011);
    chk("R11", "stop wins over start", eng_state, 2);
    req(3'b001);
    chk("R2", "restart", eng_state, 1);
    tick(); tick();
    report();
  end

endmodule